// File: doc/BRIEF.md
# Tracking Up/Down Counter Converter Controller

This block is the digital half of a tracking analog-to-digital converter. It holds an up/down counter whose value goes straight out as the code of an external digital-to-analog converter. An external comparator reports whether the analog input lies above the level that this code produces. On every enable pulse during a conversion, the counter moves one code toward the input. The loop therefore follows the input and, once it reaches it, dithers by one code around it.

A conversion begins with a start pulse. It ends in one of two ways. The first is a settle: the step direction reverses on two steps in a row, as up-down-up or down-up-down. The second is a step limit that bounds the worst case to a full-scale traverse plus a small margin. At the end the block presents the counter value on the result bus with a one-cycle valid pulse. The counter is never cleared between conversions. A slowly moving input is therefore re-acquired in a few steps, and the conversion time depends on how far the input has moved.

The comparator bit passes through a synchronizer of `SYNC_STAGES` flops before it is used. Enable pulses must therefore be spaced at least `SYNC_STAGES+1` cycles apart, so that each step sees the comparator's answer for the current code.

Top module: `trk_adc`

## Requirements
- R1: During a conversion, each cycle with `step_en` high moves `dac_code` one code. It moves up when the synchronized comparator bit is 1 (input above the DAC level) and down when it is 0. In any cycle without `step_en`, and whenever no conversion is running, `dac_code` does not change.
- R2: The counter saturates. A down step at code 0 leaves it at 0, and an up step at code 2^W-1 leaves it at 2^W-1.
- R3: A conversion settles on the enabled step whose direction differs from the previous step's direction, provided the previous step also differed from the one before it. On that step the counter does not move, and the result equals the current code.
- R4: If 2^W+2 steps have already been taken in a conversion, the next enabled step ends the conversion with the current code as the result, whether or not a settle pattern was seen.
- R5: `valid` is high for exactly one cycle, in the cycle after the final step. `result` changes only together with that pulse.
- R6: The counter keeps its value between conversions, and a new conversion starts from it.
- R7: `start` clears the direction history and the step count, and it restarts a conversion that is already running. When `start` and `step_en` are high in the same cycle, `start` wins and the counter does not move.
- R8: After reset, `dac_code` is 0, `result` is 0, `valid` is 0 and no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a conversion |
| step_en | input | 1 | Step tick; at least SYNC_STAGES+1 cycles apart |
| cmp_in | input | 1 | Comparator bit, 1 when the input is above the DAC level |
| dac_code | output | W | Counter value driving the external DAC |
| result | output | W | Last converted code |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench models the comparator as a function of the present DAC code and an input held in half-code units, so an exact tie never occurs. A bench function predicts both the number of enable pulses needed and the final code.

Two functions can fall in the same cycle:
- Start and step. The bench raises `start` and `step_en` together in the middle of a converging run. It judges the outcome by an unchanged `dac_code` and by a fresh step history afterwards.
- Settle and step-limit exit. Inputs beyond either rail keep the counter saturated until the limit step. The bench checks that this step ends the run with the rail code as the result, after exactly 2^W+3 enable pulses.

// File: rtl/trk_pkg.sv
package trk_pkg;

   typedef enum logic {
      DIR_DN = 1'b0,
      DIR_UP = 1'b1
   } dir_e;

   // number of completed steps after which the next step forces an exit
   function automatic int unsigned step_limit(input int unsigned w);
      return (32'd1 << w) + 32'd2;
   endfunction

endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trk_sync: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_two
         logic s0, s1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s0 <= 1'b0;
               s1 <= 1'b0;
            end else begin
               s0 <= d;
               s1 <= s0;
            end
         end
         assign q = s1;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/trk_counter.sv
module trk_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         move,
   input  trk_pkg::dir_e dir,
   output logic [W-1:0] code
);
   import trk_pkg::*;

   localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
   localparam logic [W-1:0] CODE_MIN = '0;

   logic at_top, at_bot;
   logic [W-1:0] code_nxt;

   assign at_top = (code == CODE_MAX);
   assign at_bot = (code == CODE_MIN);

   always_comb begin
      code_nxt = code;
      if (move) begin
         if (dir == DIR_UP) begin
            if (!at_top) code_nxt = code + 1'b1;
         end else begin
            if (!at_bot) code_nxt = code - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= code_nxt;
   end
endmodule

// File: rtl/trk_settle.sv
module trk_settle #(
   parameter int W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  trk_pkg::dir_e dir,
   output logic          finish
);
   import trk_pkg::*;

   localparam int unsigned LIMIT = step_limit(W);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

   dir_e          d1, d2;
   logic [1:0]    depth;
   logic [CW-1:0] taken;
   logic          reversal, at_limit;

   assign reversal = (depth == 2'd2) && (dir != d1) && (d1 != d2);
   assign at_limit = (taken == LIMIT_C);
   assign finish   = step && (reversal || at_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1    <= DIR_DN;
         d2    <= DIR_DN;
         depth <= 2'd0;
         taken <= '0;
      end else if (clear) begin
         depth <= 2'd0;
         taken <= '0;
      end else if (step && !finish) begin
         d2    <= d1;
         d1    <= dir;
         if (depth != 2'd2) depth <= depth + 2'd1;
         taken <= taken + 1'b1;
      end
   end
endmodule

// File: rtl/trk_adc.sv
module trk_adc #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         step_en,
   input  logic         cmp_in,
   output logic [W-1:0] dac_code,
   output logic [W-1:0] result,
   output logic         valid
);
   import trk_pkg::*;

   generate
      if (W < 2 || W > 24) begin : g_bad_width
         $error("trk_adc: W must lie in 2..24");
      end
   endgenerate

   logic cmp_s;
   logic busy;
   logic step_go;
   logic finish;
   logic move;
   dir_e dir;

   trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (cmp_in),
      .q    (cmp_s)
   );

   assign dir     = cmp_s ? DIR_UP : DIR_DN;
   assign step_go = busy && step_en && !start;
   assign move    = step_go && !finish;

   trk_settle #(.W(W)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .step  (step_go),
      .dir   (dir),
      .finish(finish)
   );

   trk_counter #(.W(W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .move (move),
      .dir  (dir),
      .code (dac_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         valid  <= 1'b0;
         result <= '0;
      end else begin
         valid <= 1'b0;
         if (start) begin
            busy <= 1'b1;
         end else if (finish) begin
            busy   <= 1'b0;
            valid  <= 1'b1;
            result <= dac_code;
         end
      end
   end
endmodule

// File: rtl/trk_chk.sv
module trk_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         step_en,
   input logic [W-1:0] dac_code,
   input logic [W-1:0] result,
   input logic         valid
);
   a_r1_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(dac_code));

   a_r2_unit_move_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |->
         (({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1) ||
          ({1'b0, $past(dac_code)} == {1'b0, dac_code} + 1'b1)));

   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   a_r5_result_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> valid);

   a_r7_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ($stable(dac_code) && !valid));
endmodule

bind trk_adc trk_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .step_en (step_en),
   .dac_code(dac_code),
   .result  (result),
   .valid   (valid)
);

// File: tb/sim_trk_adc.sv
`timescale 1ns/1ps
module sim_trk_adc;
   localparam int W     = 8;
   localparam int MAXC  = (1 << W) - 1;
   localparam int LIMIT = (1 << W) + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         step_en = 1'b0;
   logic         cmp_in;
   logic [W-1:0] dac_code;
   logic [W-1:0] result;
   logic         valid;

   int vin2 = 1;          // analog input in half-code units, always odd
   int checks = 0;
   int errors = 0;
   int model_code = 0;

   always #2.5 clk = ~clk;

   assign cmp_in = (vin2 > 2 * int'(dac_code));

   trk_adc #(.W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
      .cmp_in(cmp_in), .dac_code(dac_code), .result(result), .valid(valid)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected pulses and final code from the requirements (R1..R4)
   task automatic model(input int v2, input int c0, output int code, output int pulses);
      int  c = c0;
      int  depth = 0;
      int  taken = 0;
      bit  d1 = 0, d2 = 0, dir;
      pulses = 0;
      forever begin
         dir = (v2 > 2 * c);
         pulses++;
         if ((depth == 2 && dir != d1 && d1 != d2) || taken == LIMIT) break;
         if (dir && c < MAXC) c++;
         else if (!dir && c > 0) c--;
         d2 = d1; d1 = dir;
         if (depth < 2) depth++;
         taken++;
      end
      code = c;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_conv(input int v2, input string tag);
      int exp_code, exp_n, n;
      bit got;
      int res;
      vin2 = v2;
      model(v2, model_code, exp_code, exp_n);
      repeat (3) @(negedge clk);
      pulse_start();
      n = 0; got = 0; res = 0;
      while (!got && n < 2 * LIMIT) begin
         @(negedge clk) step_en = 1'b1;
         @(negedge clk) step_en = 1'b0;
         n++;
         if (valid) begin
            got = 1;
            res = int'(result);
            @(negedge clk);
            check(!valid, {tag, " R5 valid one cycle"}, int'(valid), 0);
         end else begin
            repeat (2) @(negedge clk);
         end
      end
      check(got && n == exp_n, {tag, " R3/R4 pulses to finish"}, n, exp_n);
      check(res == exp_code, {tag, " R3/R4 result"}, res, exp_code);
      check(int'(dac_code) == exp_code, {tag, " R6 code kept"}, int'(dac_code), exp_code);
      model_code = exp_code;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int  c_before;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      // R8 reset state
      check(dac_code == '0, "R8 dac_code at reset", int'(dac_code), 0);
      check(result == '0, "R8 result at reset", int'(result), 0);
      check(!valid, "R8 valid at reset", int'(valid), 0);
      rst_n = 1'b1;
      vin2 = 101;
      repeat (3) @(negedge clk);

      // R1 idle: steps without a conversion do nothing
      @(negedge clk) step_en = 1'b1;
      @(negedge clk) step_en = 1'b0;
      check(dac_code == '0 && !valid, "R1 idle step ignored", int'(dac_code), 0);

      // R3 basic settle from zero
      run_conv(101, "R3 track 50.5");
      // R6 re-track nearby input in few steps
      run_conv(105, "R6 retrack 52.5");
      // R1 downward tracking
      run_conv(41, "R1 down 20.5");

      // R2/R4 upper rail: saturate then step-limit exit
      run_conv(2 * MAXC + 1, "R2 R4 top rail");
      check(int'(dac_code) == MAXC, "R2 saturated top", int'(dac_code), MAXC);
      // R2/R4 lower rail
      run_conv(-1, "R2 R4 bottom rail");
      check(dac_code == '0, "R2 saturated bottom", int'(dac_code), 0);

      // R7 start and step in the same cycle mid-conversion
      vin2 = 61;
      repeat (3) @(negedge clk);
      pulse_start();
      repeat (3) begin
         @(negedge clk) step_en = 1'b1;
         @(negedge clk) step_en = 1'b0;
         repeat (2) @(negedge clk);
      end
      c_before = int'(dac_code);
      @(negedge clk) begin start = 1'b1; step_en = 1'b1; end
      @(negedge clk) begin start = 1'b0; step_en = 1'b0; end
      check(int'(dac_code) == c_before && !valid, "R7 start beats step",
            int'(dac_code), c_before);
      model_code = c_before;
      repeat (2) @(negedge clk);
      run_conv(61, "R7 after restart");

      // random inputs, including occasional rails
      for (int i = 0; i < 16; i++) begin
         int v;
         v = 2 * int'($urandom % (MAXC + 1)) + 1;
         if (($urandom % 8) == 0) v = -1;
         run_conv(v, "R1 R3 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule